// File: doc/BRIEF.md
# Zoned Bit-Cell Clock Recovery

This block produces the bit-cell timing for a disk read/write data path. A two-bit zone select picks the nominal length of a bit cell in system-clock ticks. In write mode a free-running phase counter marks off cells at that length and raises a one-cycle bit strobe at the end of each cell. The flux input plays no part in write mode.

In read mode the same counter is pulled into step by the incoming flux transitions. Each transition restarts the counter at the middle of a cell. The cell that holds a transition is reported as a one. Each full cell of silence after it is reported as a zero, sampled in the centre of the empty cell. The flux input is a clean pulse, one system clock wide and already synchronised to `clk`. Analog pulse detection happens upstream.

The zone select is taken up only at cell boundaries, so a zone change never shortens or stretches a cell already in progress. Reset is synchronous and active high.

Top module: `zoned_bitclock`

## Requirements
- R1: A cell lasts 13 + zoneSel system-clock ticks (zone 0 = 13, 1 = 14, 2 = 15, 3 = 16). Without flux activity, consecutive bitValid strobes are exactly that many cycles apart.
- R2: With writeMode = 1, the strobe spacing is the cell length whatever fluxPulse does, and every strobe carries bitValue = 0.
- R3: With writeMode = 0, a flux pulse sampled at a clock edge produces a strobe with bitValue = 1 exactly L - floor(L/2) edges later (L is the cell length): 8 edges in zones 3 and 2, 7 edges in zones 1 and 0.
- R4: With writeMode = 0 and no flux pulse, each strobe follows the previous one by exactly one cell length and carries bitValue = 0.
- R5: bitValid is high for one cycle only, and there is exactly one strobe per cell. A read-mode pulse sampled on the last tick of a cell suppresses that cell's strobe: the next strobe is the one-bit strobe of R3.
- R6: A zoneSel change made part-way through a cell leaves that cell at its old length. The new length applies from the following cell.
- R7: While rst is high, bitValid stays low and flux pulses are ignored. The first strobe after release comes on the L-th rising edge after rst falls, where L is the length selected at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| zoneSel | input | 2 | Speed-zone select; the cell length is 13 + zoneSel ticks |
| writeMode | input | 1 | 1 = cells come from the divider alone; 0 = cells follow flux pulses |
| fluxPulse | input | 1 | Synchronised single-cycle flux-transition pulse |
| bitValid | output | 1 | One-cycle strobe at the end of each bit cell |
| bitValue | output | 1 | Recovered bit, valid while bitValid is high (0 in write mode) |

## Verification
A phase counter that drifts or loads the wrong midpoint shows up at once as the wrong strobe spacing. The strobe after the faulty cell arrives a cycle or more early or late. A cell length latched at the wrong moment shows up within one cell of a zone change, as the first interval after the change taking the new length. A one-flag that is not cleared, or that is cleared too early, flips bitValue on the very next strobe. A mishandled pulse at a boundary shows up as an extra strobe or a missing one-bit.

// File: rtl/zoned_bitclock_pkg.sv
package zoned_bitclock_pkg;

  // Strobes passed from the cell timer (control) to the bit shaper (datapath).
  typedef struct packed {
    logic cellEnd;   // last tick of a cell elapsed, no resync on this edge
    logic fluxLoad;  // read-mode flux pulse accepted on this edge
    logic readMode;  // cells are following flux transitions
  } cellCtl_t;

endpackage

// File: rtl/bitcell_timer.sv
module bitcell_timer
  import zoned_bitclock_pkg::*;
#(
  parameter int BASE_PERIOD = 13,
  parameter int ZONE_BITS   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ZONE_BITS-1:0] zoneSel,
  input  logic                 writeMode,
  input  logic                 fluxPulse,
  output cellCtl_t             ctl
);

  localparam int NUM_ZONES = 1 << ZONE_BITS;
  localparam int CNT_W     = $clog2(BASE_PERIOD + NUM_ZONES);

  // Cell length for each zone, one table entry per zone.
  logic [CNT_W-1:0] zoneLen [NUM_ZONES];
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign zoneLen[z] = CNT_W'(BASE_PERIOD + z);
  end

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] cellLen;
  logic [CNT_W-1:0] lastPhase;
  logic [CNT_W-1:0] midPhase;
  logic             atEnd;
  logic             fluxLoad;

  assign lastPhase = cellLen - 1'b1;
  assign midPhase  = cellLen >> 1;
  assign atEnd     = (phase == lastPhase);
  assign fluxLoad  = !writeMode && fluxPulse;

  // Phase counter. A flux reload has priority over the cell boundary.
  // The cell length is latched only in reset and at a boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      cellLen <= zoneLen[zoneSel];
    end else if (fluxLoad) begin
      phase   <= midPhase;
    end else if (atEnd) begin
      phase   <= '0;
      cellLen <= zoneLen[zoneSel];
    end else begin
      phase   <= phase + 1'b1;
    end
  end

  always_comb begin
    ctl.cellEnd  = atEnd && !fluxLoad && !rst;
    ctl.fluxLoad = fluxLoad && !rst;
    ctl.readMode = !writeMode;
  end

  assert_phase_in_cell_R1: assert property (@(posedge clk) disable iff (rst)
    phase < cellLen);

  assert_len_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    (cellLen >= CNT_W'(BASE_PERIOD)) && (cellLen <= CNT_W'(BASE_PERIOD + NUM_ZONES - 1)));

  assert_len_holds_mid_cell_R6: assert property (@(posedge clk) disable iff (rst)
    !atEnd |=> $stable(cellLen));

  assert_flux_reload_mid_R3: assert property (@(posedge clk) disable iff (rst)
    fluxLoad |=> (phase == (cellLen >> 1)));

  assert_write_ignores_flux_R2: assert property (@(posedge clk) disable iff (rst)
    (writeMode && !atEnd) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/bitcell_shaper.sv
module bitcell_shaper
  import zoned_bitclock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cellCtl_t ctl,
  output logic     bitValid,
  output logic     bitValue
);

  logic oneSeen;

  // oneSeen records a transition in the current cell; it is cleared at each
  // reported boundary and held at zero in write mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      oneSeen  <= 1'b0;
      bitValid <= 1'b0;
      bitValue <= 1'b0;
    end else begin
      bitValid <= ctl.cellEnd;
      if (ctl.cellEnd) begin
        bitValue <= ctl.readMode && oneSeen;
      end
      if (!ctl.readMode) begin
        oneSeen <= 1'b0;
      end else if (ctl.fluxLoad) begin
        oneSeen <= 1'b1;
      end else if (ctl.cellEnd) begin
        oneSeen <= 1'b0;
      end
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    bitValid |=> !bitValid);

  assert_flux_defers_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.fluxLoad |=> !bitValid);

  assert_write_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.cellEnd && !ctl.readMode) |=> (bitValid && !bitValue));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> !bitValid);

endmodule

// File: rtl/zoned_bitclock.sv
module zoned_bitclock
  import zoned_bitclock_pkg::*;
#(
  parameter int BASE_PERIOD = 13,
  parameter int ZONE_BITS   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ZONE_BITS-1:0] zoneSel,
  input  logic                 writeMode,
  input  logic                 fluxPulse,
  output logic                 bitValid,
  output logic                 bitValue
);

  cellCtl_t ctl;

  bitcell_timer #(
    .BASE_PERIOD(BASE_PERIOD),
    .ZONE_BITS  (ZONE_BITS)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .zoneSel  (zoneSel),
    .writeMode(writeMode),
    .fluxPulse(fluxPulse),
    .ctl      (ctl)
  );

  bitcell_shaper shaper_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .bitValid(bitValid),
    .bitValue(bitValue)
  );

endmodule

// File: tb/zoned_bitclock_tb_top.sv
module zoned_bitclock_tb_top;

  localparam int BASE = 13;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] zoneSel = 2'd2;
  logic       writeMode = 1'b0;
  logic       fluxPulse = 1'b0;
  logic       bitValid;
  logic       bitValue;

  always #5 clk = ~clk;

  zoned_bitclock #(.BASE_PERIOD(BASE), .ZONE_BITS(2)) dut_i (
    .clk(clk), .rst(rst), .zoneSel(zoneSel), .writeMode(writeMode),
    .fluxPulse(fluxPulse), .bitValid(bitValid), .bitValue(bitValue)
  );

  // {writeMode, zoneSel, 8 bits sent MSB first}
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b1, 2'd0, 8'hA5},
    {1'b1, 2'd3, 8'h3C},
    {1'b0, 2'd3, 8'hB1},
    {1'b0, 2'd2, 8'h6E},
    {1'b0, 2'd1, 8'h0F},
    {1'b0, 2'd0, 8'hD2},
    {1'b0, 2'd0, 8'h00},
    {1'b1, 2'd2, 8'hFF}
  };

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until bitValid is seen (sampled 1 ns after the edge).
  task automatic waitStrobe(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!bitValid && n < 200);
  endtask

  function automatic int lenOf(input logic [1:0] z);
    return BASE + int'(z);
  endfunction

  function automatic int oneLat(input logic [1:0] z);
    return lenOf(z) - lenOf(z) / 2;
  endfunction

  initial begin
    int n;
    int n2;
    int got;
    int exp;
    bit want;

    // R7: quiet during reset even with flux activity
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check(bitValid == 1'b0, "R7 strobe during reset", int'(bitValid), 0);
      fluxPulse = ~fluxPulse;
    end
    fluxPulse = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    waitStrobe(n);
    check(n == 15, "R7 first strobe after release (zone 2)", n, 15);
    check(bitValue == 1'b0, "R4 empty cell value", int'(bitValue), 0);

    // Vector table: R1 R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      writeMode = VECS[v][10];
      zoneSel   = VECS[v][9:8];
      waitStrobe(n);
      waitStrobe(n);
      for (int b = 7; b >= 0; b--) begin
        if (VECS[v][b]) begin
          @(posedge clk); #1 fluxPulse = 1'b1;
          @(posedge clk); #1 fluxPulse = 1'b0;
          waitStrobe(n);
          got = n + 2;
        end else begin
          waitStrobe(n);
          got = n;
        end
        want = VECS[v][b] && !writeMode;
        exp  = want ? oneLat(zoneSel) + 2 : lenOf(zoneSel);
        if (writeMode) begin
          check(got == exp, "R2 write spacing", got, exp);
          check(bitValue == 1'b0, "R2 write value", int'(bitValue), 0);
        end else if (want) begin
          check(got == exp, "R3 one-bit latency", got, exp);
          check(bitValue == 1'b1, "R3 one-bit value", int'(bitValue), 1);
        end else begin
          check(got == exp, "R4 zero-bit spacing R1", got, exp);
          check(bitValue == 1'b0, "R4 zero-bit value", int'(bitValue), 0);
        end
      end
    end

    // R6: zone change mid-cell
    writeMode = 1'b1;
    zoneSel   = 2'd0;
    waitStrobe(n);
    waitStrobe(n);
    repeat (5) begin @(posedge clk); #1; end
    zoneSel = 2'd3;
    waitStrobe(n);
    check(n + 5 == 13, "R6 current cell keeps old length", n + 5, 13);
    waitStrobe(n);
    check(n == 16, "R6 next cell takes new length", n, 16);

    // R5: pulse on the last tick of a cell (zone 3, read)
    writeMode = 1'b0;
    waitStrobe(n);
    waitStrobe(n);
    repeat (15) begin @(posedge clk); #1; end
    check(bitValid == 1'b0, "R5 no strobe before boundary", int'(bitValid), 0);
    fluxPulse = 1'b1;
    @(posedge clk); #1 fluxPulse = 1'b0;
    check(bitValid == 1'b0, "R5 boundary strobe suppressed", int'(bitValid), 0);
    waitStrobe(n2);
    check(n2 + 1 == 9, "R5 deferred one-bit latency", n2 + 1, 9);
    check(bitValue == 1'b1, "R5 deferred one-bit value", int'(bitValue), 1);
    @(posedge clk); #1;
    check(bitValid == 1'b0, "R5 strobe one cycle wide", int'(bitValid), 0);

    // R7: reset in the middle of a cell
    writeMode = 1'b1;
    zoneSel   = 2'd0;
    waitStrobe(n);
    repeat (4) begin @(posedge clk); #1; end
    rst = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    check(bitValid == 1'b0, "R7 quiet in mid-run reset", int'(bitValid), 0);
    rst = 1'b0;
    waitStrobe(n);
    check(n == 13, "R7 first strobe after mid-run reset", n, 13);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule